// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block resolves the memory operand named by a real-mode ModRM byte into a 16-bit effective offset, a segment identifier and a 20-bit linear address, and reports how many cycles that addressing form costs. The caller supplies the ModRM byte, the four address registers that can take part in the sum (BX, BP, SI, DI), up to two displacement bytes that were already fetched, the segment-override state, and the four segment register values. The result is registered and appears one clock after the request, qualified by a valid flag.

The segment identifier is carried as its own output next to the offset, so a later permission stage can look up the rights of the segment that was actually used. A ModRM value that names a register instead of memory produces no address; only a bypass flag is raised.

Top module: `eag_top`

## Requirements
- R1: With mod=00 the r/m field selects the offset BX+SI (0), BX+DI (1), BP+SI (2), BP+DI (3), SI (4), DI (5), a direct 16-bit address taken from the displacement bytes (6), or BX (7).
- R2: With mod=01 the low displacement byte is sign-extended to 16 bits and added to the r/m base; with mod=01 and mod=10, r/m 6 uses BP as the base.
- R3: With mod=10 (and for the mod=00 direct address) the displacement is the 16-bit value {dispHi, dispLo}, low byte first.
- R4: With no override, every form that adds BP reports segment SS; all other forms, the direct address included, report DS. Segment ids: ES=0, CS=1, SS=2, DS=3.
- R5: When ovrValid is high, the reported segment is ovrSeg, since every memory form has a DS or SS default and only those defaults are replaceable.
- R6: The offset sum wraps modulo 2^16 before the segment base is added.
- R7: outLinear equals (value of the reported segment register shifted left by 4) plus the offset, truncated to 20 bits.
- R8: outCycles is 7, 8, 8, 7, 5, 5, 6, 5 for mod=00 r/m 0 to 7, and 11, 12, 12, 11, 9, 9, 9, 9 for mod=01 and mod=10.
- R9: A ModRM value of 0xC0 or above sets outRegDirect and drives outOffset, outSeg, outLinear and outCycles to zero, whatever the override inputs are.
- R10: Outputs reflect the inputs sampled at the edge where inValid is high and appear one clock later with outValid high; when inValid is low, outValid falls and the other outputs keep their values.
- R11: Reset clears outValid, outRegDirect and all result outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Request strobe, inputs captured when high |
| modRm | input | 8 | ModRM byte |
| regBx | input | 16 | BX value |
| regBp | input | 16 | BP value |
| regSi | input | 16 | SI value |
| regDi | input | 16 | DI value |
| dispLo | input | 8 | First displacement byte |
| dispHi | input | 8 | Second displacement byte |
| ovrValid | input | 1 | Segment override active |
| ovrSeg | input | 2 | Override segment id |
| segEs | input | 16 | ES register value |
| segCs | input | 16 | CS register value |
| segSs | input | 16 | SS register value |
| segDs | input | 16 | DS register value |
| outValid | output | 1 | Result valid |
| outRegDirect | output | 1 | Register operand, no address generated |
| outOffset | output | 16 | Effective offset |
| outSeg | output | 2 | Segment id used |
| outLinear | output | 20 | Linear address |
| outCycles | output | 4 | Cycle cost of the addressing form |

## Verification
The bench builds the block with its default parameters: a 16-bit offset, a 20-bit linear address and a 4-bit segment shift. At these values register sums above 0xFFFF and segment bases near 0xFFFF0 are easy to reach, so both the offset wrap and the truncation of the linear address above one megabyte are exercised by directed cases as well as by random register values. Random ModRM bytes cover all 256 codes, including the register forms and overrides of every segment id.

// File: rtl/eag_pkg.sv
package eag_pkg;
  parameter int CYC_W = 4;

  typedef enum logic [1:0] {
    SEG_ES = 2'd0,
    SEG_CS = 2'd1,
    SEG_SS = 2'd2,
    SEG_DS = 2'd3
  } segId_e;

  typedef enum logic [1:0] {
    DISP_NONE = 2'd0,
    DISP_BYTE = 2'd1,
    DISP_WORD = 2'd2
  } dispKind_e;

  // Strobes from the decode control to the address datapath.
  typedef struct packed {
    logic             regDirect;
    logic [3:0]       addMask;   // bit0 BX, bit1 BP, bit2 SI, bit3 DI
    dispKind_e        dispKind;
    segId_e           seg;
    logic [CYC_W-1:0] cycles;
  } eagStrobes_t;
endpackage

// File: rtl/eag_ctrl.sv
module eag_ctrl
  import eag_pkg::*;
(
  input  logic [1:0]  modField,
  input  logic [2:0]  rmField,
  input  logic        ovrValid,
  input  logic [1:0]  ovrSeg,
  output eagStrobes_t strobes
);
  localparam logic [3:0] M_BX = 4'b0001;
  localparam logic [3:0] M_BP = 4'b0010;
  localparam logic [3:0] M_SI = 4'b0100;
  localparam logic [3:0] M_DI = 4'b1000;

  logic       isReg;
  logic       isDirect;
  logic [3:0] mask;
  segId_e     defSeg;
  logic [CYC_W-1:0] baseCost;

  always_comb begin
    isReg    = (modField == 2'b11);
    isDirect = (modField == 2'b00) && (rmField == 3'd6);
    unique case (rmField)
      3'd0: mask = M_BX | M_SI;
      3'd1: mask = M_BX | M_DI;
      3'd2: mask = M_BP | M_SI;
      3'd3: mask = M_BP | M_DI;
      3'd4: mask = M_SI;
      3'd5: mask = M_DI;
      3'd6: mask = isDirect ? 4'b0000 : M_BP;
      default: mask = M_BX;
    endcase
    defSeg = mask[1] ? SEG_SS : SEG_DS;

    // Cost of the no-displacement form; displacement adds four except
    // for the single-register forms, which settle at nine.
    unique case (rmField)
      3'd0, 3'd3: baseCost = CYC_W'(7);
      3'd1, 3'd2: baseCost = CYC_W'(8);
      3'd6:       baseCost = CYC_W'(6);
      default:    baseCost = CYC_W'(5);
    endcase

    strobes = '0;
    if (!isReg) begin
      strobes.addMask = mask;
      if (modField == 2'b01)      strobes.dispKind = DISP_BYTE;
      else if (modField == 2'b10) strobes.dispKind = DISP_WORD;
      else if (isDirect)          strobes.dispKind = DISP_WORD;
      else                        strobes.dispKind = DISP_NONE;
      if (ovrValid && (defSeg == SEG_DS || defSeg == SEG_SS))
        strobes.seg = segId_e'(ovrSeg);
      else
        strobes.seg = defSeg;
      if (modField == 2'b00)
        strobes.cycles = baseCost;
      else if (rmField[2])
        strobes.cycles = CYC_W'(9);
      else
        strobes.cycles = baseCost + CYC_W'(4);
    end else begin
      strobes.regDirect = 1'b1;
      strobes.dispKind  = DISP_NONE;
      strobes.seg       = SEG_ES;
    end
  end
endmodule

// File: rtl/eag_datapath.sv
module eag_datapath
  import eag_pkg::*;
#(
  parameter int OFS_W     = 16,
  parameter int ADDR_W    = 20,
  parameter int SEG_SHIFT = 4,
  parameter int NUM_BASE  = 4,
  parameter int NUM_SEG   = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   inValid,
  input  eagStrobes_t            strobes,
  input  logic [OFS_W-1:0]       baseRegs [NUM_BASE],
  input  logic [7:0]             dispLo,
  input  logic [OFS_W-9:0]       dispHi,
  input  logic [OFS_W-1:0]       segRegs  [NUM_SEG],
  output logic                   outValid,
  output logic                   outRegDirect,
  output logic [OFS_W-1:0]       outOffset,
  output logic [1:0]             outSeg,
  output logic [ADDR_W-1:0]      outLinear,
  output logic [CYC_W-1:0]       outCycles
);
  localparam int EXT_W = OFS_W - 8;
  localparam int PAD_W = ADDR_W - OFS_W;

  logic [OFS_W-1:0]  terms [NUM_BASE];
  logic [OFS_W-1:0]  dispExt;
  logic [OFS_W-1:0]  offNext;
  logic [OFS_W-1:0]  segVal;
  logic [ADDR_W-1:0] segBase;
  logic [ADDR_W-1:0] linNext;

  for (genvar k = 0; k < NUM_BASE; k++) begin : g_term
    assign terms[k] = strobes.addMask[k] ? baseRegs[k] : '0;
  end

  always_comb begin
    unique case (strobes.dispKind)
      DISP_BYTE: dispExt = {{EXT_W{dispLo[7]}}, dispLo};
      DISP_WORD: dispExt = {dispHi, dispLo};
      default:   dispExt = '0;
    endcase
    offNext = dispExt;
    for (int k = 0; k < NUM_BASE; k++) offNext = offNext + terms[k];
    segVal  = segRegs[strobes.seg];
    segBase = {{PAD_W{1'b0}}, segVal} << SEG_SHIFT;
    linNext = segBase + {{PAD_W{1'b0}}, offNext};
    if (strobes.regDirect) begin
      offNext = '0;
      linNext = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outValid     <= 1'b0;
      outRegDirect <= 1'b0;
      outOffset    <= '0;
      outSeg       <= '0;
      outLinear    <= '0;
      outCycles    <= '0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        outRegDirect <= strobes.regDirect;
        outOffset    <= offNext;
        outSeg       <= strobes.seg;
        outLinear    <= linNext;
        outCycles    <= strobes.cycles;
      end
    end
  end
endmodule

// File: rtl/eag_top.sv
module eag_top
  import eag_pkg::*;
#(
  parameter int OFS_W     = 16,
  parameter int ADDR_W    = 20,
  parameter int SEG_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  input  logic [7:0]        modRm,
  input  logic [OFS_W-1:0]  regBx,
  input  logic [OFS_W-1:0]  regBp,
  input  logic [OFS_W-1:0]  regSi,
  input  logic [OFS_W-1:0]  regDi,
  input  logic [7:0]        dispLo,
  input  logic [OFS_W-9:0]  dispHi,
  input  logic              ovrValid,
  input  logic [1:0]        ovrSeg,
  input  logic [OFS_W-1:0]  segEs,
  input  logic [OFS_W-1:0]  segCs,
  input  logic [OFS_W-1:0]  segSs,
  input  logic [OFS_W-1:0]  segDs,
  output logic              outValid,
  output logic              outRegDirect,
  output logic [OFS_W-1:0]  outOffset,
  output logic [1:0]        outSeg,
  output logic [ADDR_W-1:0] outLinear,
  output logic [CYC_W-1:0]  outCycles
);
  localparam int NUM_BASE = 4;
  localparam int NUM_SEG  = 4;

  eagStrobes_t      strobes;
  logic [OFS_W-1:0] baseRegs [NUM_BASE];
  logic [OFS_W-1:0] segRegs  [NUM_SEG];
  logic [2:0]       unusedRegBits;

  assign unusedRegBits = modRm[5:3];
  assign baseRegs[0] = regBx;
  assign baseRegs[1] = regBp;
  assign baseRegs[2] = regSi;
  assign baseRegs[3] = regDi;
  assign segRegs[SEG_ES] = segEs;
  assign segRegs[SEG_CS] = segCs;
  assign segRegs[SEG_SS] = segSs;
  assign segRegs[SEG_DS] = segDs;

  eag_ctrl u_ctrl (
    .modField (modRm[7:6]),
    .rmField  (modRm[2:0]),
    .ovrValid (ovrValid),
    .ovrSeg   (ovrSeg),
    .strobes  (strobes)
  );

  eag_datapath #(
    .OFS_W     (OFS_W),
    .ADDR_W    (ADDR_W),
    .SEG_SHIFT (SEG_SHIFT),
    .NUM_BASE  (NUM_BASE),
    .NUM_SEG   (NUM_SEG)
  ) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .inValid      (inValid),
    .strobes      (strobes),
    .baseRegs     (baseRegs),
    .dispLo       (dispLo),
    .dispHi       (dispHi),
    .segRegs      (segRegs),
    .outValid     (outValid),
    .outRegDirect (outRegDirect),
    .outOffset    (outOffset),
    .outSeg       (outSeg),
    .outLinear    (outLinear),
    .outCycles    (outCycles)
  );
endmodule

// File: rtl/eag_checker.sv
module eag_checker #(
  parameter int OFS_W     = 16,
  parameter int ADDR_W    = 20,
  parameter int SEG_SHIFT = 4,
  parameter int CYC_W     = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              inValid,
  input logic [7:0]        modRm,
  input logic              ovrValid,
  input logic [OFS_W-1:0]  segEs,
  input logic [OFS_W-1:0]  segCs,
  input logic [OFS_W-1:0]  segSs,
  input logic [OFS_W-1:0]  segDs,
  input logic              outValid,
  input logic              outRegDirect,
  input logic [OFS_W-1:0]  outOffset,
  input logic [1:0]        outSeg,
  input logic [ADDR_W-1:0] outLinear,
  input logic [CYC_W-1:0]  outCycles
);
  localparam int PAD_W = ADDR_W - OFS_W;

  logic [OFS_W-1:0] pEs, pCs, pSs, pDs, pSel;
  logic [ADDR_W-1:0] linRef;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pEs <= '0; pCs <= '0; pSs <= '0; pDs <= '0;
    end else begin
      pEs <= segEs; pCs <= segCs; pSs <= segSs; pDs <= segDs;
    end
  end

  always_comb begin
    unique case (outSeg)
      2'd0:    pSel = pEs;
      2'd1:    pSel = pCs;
      2'd2:    pSel = pSs;
      default: pSel = pDs;
    endcase
    linRef = ({{PAD_W{1'b0}}, pSel} << SEG_SHIFT) + {{PAD_W{1'b0}}, outOffset};
  end

  // R10: request is answered exactly one cycle later
  a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);
  a_r10_idle_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !outValid);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> ($stable(outOffset) && $stable(outLinear) && $stable(outSeg)));
  // R9: register forms produce no address and no cost
  a_r9_bypass_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && modRm >= 8'hC0) |=> (outRegDirect && outOffset == '0 &&
                                     outLinear == '0 && outCycles == '0));
  // R4: without override the segment is SS or DS
  a_r4_default_seg: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && !ovrValid && modRm < 8'hC0) |=> (outSeg == 2'd2 || outSeg == 2'd3));
  // R8: every memory form costs between five and twelve cycles
  a_r8_cost_range: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outRegDirect) |-> (outCycles >= CYC_W'(5) && outCycles <= CYC_W'(12)));
  // R7: linear address agrees with the segment register seen at capture
  a_r7_linear: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outRegDirect) |-> (outLinear == linRef));
  // R11: nothing is valid on the first edge after reset
  a_r11_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !outValid);
endmodule

bind eag_top eag_checker #(
  .OFS_W     (OFS_W),
  .ADDR_W    (ADDR_W),
  .SEG_SHIFT (SEG_SHIFT),
  .CYC_W     (eag_pkg::CYC_W)
) u_eag_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .inValid      (inValid),
  .modRm        (modRm),
  .ovrValid     (ovrValid),
  .segEs        (segEs),
  .segCs        (segCs),
  .segSs        (segSs),
  .segDs        (segDs),
  .outValid     (outValid),
  .outRegDirect (outRegDirect),
  .outOffset    (outOffset),
  .outSeg       (outSeg),
  .outLinear    (outLinear),
  .outCycles    (outCycles)
);

// File: tb/test_eag_top.sv
`timescale 1ns/1ps
module test_eag_top;
  localparam real CYCLE = 8.0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic [7:0]  modRm = '0;
  logic [15:0] regBx = '0, regBp = '0, regSi = '0, regDi = '0;
  logic [7:0]  dispLo = '0, dispHi = '0;
  logic        ovrValid = 1'b0;
  logic [1:0]  ovrSeg = '0;
  logic [15:0] segEs = '0, segCs = '0, segSs = '0, segDs = '0;
  logic        outValid, outRegDirect;
  logic [15:0] outOffset;
  logic [1:0]  outSeg;
  logic [19:0] outLinear;
  logic [3:0]  outCycles;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CYCLE/2) clk = ~clk;

  eag_top i_eag_top (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .modRm(modRm),
    .regBx(regBx), .regBp(regBp), .regSi(regSi), .regDi(regDi),
    .dispLo(dispLo), .dispHi(dispHi), .ovrValid(ovrValid), .ovrSeg(ovrSeg),
    .segEs(segEs), .segCs(segCs), .segSs(segSs), .segDs(segDs),
    .outValid(outValid), .outRegDirect(outRegDirect), .outOffset(outOffset),
    .outSeg(outSeg), .outLinear(outLinear), .outCycles(outCycles)
  );

  logic [15:0] eOff;
  logic [1:0]  eSeg;
  logic [19:0] eLin;
  logic [3:0]  eCyc;
  logic        eByp;

  function automatic void model(output logic [15:0] off, output logic [1:0] sg,
                                output logic [19:0] lin, output logic [3:0] cyc,
                                output logic byp);
    logic [1:0]  md = modRm[7:6];
    logic [2:0]  rm = modRm[2:0];
    logic [15:0] disp, base, sv;
    logic        bpUsed;
    if (md == 2'b11) begin
      off = 0; sg = 0; lin = 0; cyc = 0; byp = 1'b1;
      return;
    end
    byp = 1'b0;
    if (md == 2'b01)      disp = {{8{dispLo[7]}}, dispLo};
    else if (md == 2'b10) disp = {dispHi, dispLo};
    else if (rm == 3'd6)  disp = {dispHi, dispLo};
    else                  disp = 16'h0;
    case (rm)
      3'd0: base = regBx + regSi;
      3'd1: base = regBx + regDi;
      3'd2: base = regBp + regSi;
      3'd3: base = regBp + regDi;
      3'd4: base = regSi;
      3'd5: base = regDi;
      3'd6: base = (md == 2'b00) ? 16'h0 : regBp;
      default: base = regBx;
    endcase
    off = base + disp;
    bpUsed = (rm == 3'd2) || (rm == 3'd3) || (rm == 3'd6 && md != 2'b00);
    sg = bpUsed ? 2'd2 : 2'd3;
    if (ovrValid) sg = ovrSeg;
    if (md == 2'b00) begin
      case (rm)
        3'd0: cyc = 7; 3'd1: cyc = 8; 3'd2: cyc = 8; 3'd3: cyc = 7;
        3'd6: cyc = 6; default: cyc = 5;
      endcase
    end else begin
      case (rm)
        3'd0: cyc = 11; 3'd1: cyc = 12; 3'd2: cyc = 12; 3'd3: cyc = 11;
        default: cyc = 9;
      endcase
    end
    case (sg)
      2'd0: sv = segEs; 2'd1: sv = segCs; 2'd2: sv = segSs; default: sv = segDs;
    endcase
    lin = {sv, 4'h0} + {4'h0, off};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Drive one request at a falling edge and check it one clock later.
  task automatic run(input string req);
    inValid = 1'b1;
    model(eOff, eSeg, eLin, eCyc, eByp);
    @(negedge clk);
    chk("R10", "valid", 32'(outValid), 32'd1);
    chk(req, "offset", 32'(outOffset), 32'(eOff));
    chk(req, "segment", 32'(outSeg), 32'(eSeg));
    chk(req, "linear", 32'(outLinear), 32'(eLin));
    chk(req, "cycles", 32'(outCycles), 32'(eCyc));
    chk(req, "bypass", 32'(outRegDirect), 32'(eByp));
  endtask

  task automatic setRegs(input logic [15:0] bx, bp, si, di);
    regBx = bx; regBp = bp; regSi = si; regDi = di;
  endtask

  initial begin
    #(CYCLE * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EA1_2A6B));
    segEs = 16'h1000; segCs = 16'h2000; segSs = 16'h3000; segDs = 16'h4000;
    setRegs(16'h0100, 16'h0200, 16'h0030, 16'h0004);
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11", "valid", 32'(outValid), 0);
    chk("R11", "linear", 32'(outLinear), 0);
    chk("R11", "cycles", 32'(outCycles), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1, R4, R8: every mod=00 form with direct-address displacement bytes
    dispLo = 8'h34; dispHi = 8'h12;
    for (int r = 0; r < 8; r++) begin
      modRm = {2'b00, 3'b010, 3'(r)};
      run("R1");
    end
    // R2: negative byte displacement, BP base for r/m 6
    dispLo = 8'hF0; dispHi = 8'hAA;
    for (int r = 0; r < 8; r++) begin
      modRm = {2'b01, 3'b000, 3'(r)};
      run("R2");
    end
    // R3: word displacement
    dispLo = 8'h78; dispHi = 8'h56;
    for (int r = 0; r < 8; r++) begin
      modRm = {2'b10, 3'b101, 3'(r)};
      run("R3");
    end
    // R6: offset wrap, and R7: linear truncation above one megabyte
    setRegs(16'hFFF0, 16'h0000, 16'h0025, 16'h0000);
    segDs = 16'hFFFF;
    dispLo = 8'h00; dispHi = 8'h00;
    modRm = 8'h00;
    run("R6");
    setRegs(16'h0020, 16'h0000, 16'h0000, 16'h0000);
    modRm = 8'h07;
    run("R7");
    // R5: override of each segment id on an SS-default and a DS-default form
    segDs = 16'h4000;
    setRegs(16'h1111, 16'h2222, 16'h0333, 16'h0044);
    ovrValid = 1'b1;
    for (int s = 0; s < 4; s++) begin
      ovrSeg = 2'(s);
      modRm = 8'h46; dispLo = 8'h05;
      run("R5");
      modRm = 8'h06; dispHi = 8'h80;
      run("R5");
    end
    // R9: register form with override active
    modRm = 8'hC3;
    run("R9");
    modRm = 8'hFF; ovrValid = 1'b0;
    run("R9");
    // R10: idle cycle keeps results while inputs change
    modRm = 8'h01;
    run("R10");
    inValid = 1'b0;
    modRm = 8'h82; setRegs(16'h7777, 16'h6666, 16'h5555, 16'h4444);
    @(negedge clk);
    chk("R10", "idle valid", 32'(outValid), 0);
    chk("R10", "held offset", 32'(outOffset), 32'(eOff));
    chk("R10", "held linear", 32'(outLinear), 32'(eLin));

    // Random mix across all codes, registers and overrides
    for (int n = 0; n < 2000; n++) begin
      modRm  = 8'($urandom);
      setRegs(16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom));
      dispLo = 8'($urandom); dispHi = 8'($urandom);
      ovrValid = ($urandom % 3) == 0;
      ovrSeg = 2'($urandom);
      segEs = 16'($urandom); segCs = 16'($urandom);
      segSs = 16'($urandom); segDs = 16'($urandom);
      if (($urandom % 8) == 0) begin
        inValid = 1'b0;
        @(negedge clk);
        chk("R10", "random idle valid", 32'(outValid), 0);
        chk("R10", "random held offset", 32'(outOffset), 32'(eOff));
      end else begin
        run(modRm >= 8'hC0 ? "R9" : "R7");
      end
    end
    inValid = 1'b0;
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule